// File: doc/BRIEF.md
# Double-Precision Compare Flag Generator

This block compares two 64-bit IEEE-754 double-precision operand patterns and produces an updated condition-flag register. It uses unordered-compare rules. A compare is issued by raising `in_valid` for one cycle with both operands and the current flag register. One cycle later, `out_valid` pulses and `flags_o` carries the new flag word.

Six flag bits are owned by the compare: carry, parity, auxiliary, zero, sign and overflow. Every other bit of the incoming flag word passes through unchanged. The relation of the two operands selects the values of the zero, parity and carry bits. The overflow, sign and auxiliary bits always come out cleared. Between compares the registered flag word holds its last value.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is asserted and at the first edge after it, `out_valid` is 0 and `flags_o` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. The flag result of a compare presented at edge N is on `flags_o` after edge N, and back-to-back compares are each produced.
- R3: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. If either operand is a NaN, zero (bit 6), parity (bit 2) and carry (bit 0) are all 1.
- R4: If the operands are ordered and the first is less than the second, carry (bit 0) is 1 and zero (bit 6) and parity (bit 2) are 0.
- R5: If the operands are ordered and equal, zero (bit 6) is 1 and parity (bit 2) and carry (bit 0) are 0. Positive zero and negative zero compare equal.
- R6: If the operands are ordered and the first is greater than the second, zero (bit 6), parity (bit 2) and carry (bit 0) are all 0.
- R7: Every compare result has overflow (bit 11), sign (bit 7) and auxiliary (bit 4) cleared, whatever the incoming flags.
- R8: All flag bits other than bits 0, 2, 4, 6, 7 and 11 are copied from `flags_i` into the result unchanged.
- R9: Ordering follows sign-magnitude rules (bit 63 is the sign). Any negative value is less than any positive one, and of two negatives the larger magnitude is the lesser value. Infinities (exponent all ones, fraction zero) are ordered values and not NaNs.
- R10: In a cycle where `in_valid` is 0, `flags_o` keeps its previous value, whatever `opa_i`, `opb_i` and `flags_i` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Compare request strobe |
| opa_i | input | 64 | First operand, double-precision bit pattern |
| opb_i | input | 64 | Second operand, double-precision bit pattern |
| flags_i | input | 16 | Current flag register |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| flags_o | output | 16 | Updated flag register (held between compares) |

## Verification
The hardest situations to reach from the ports are those that random 64-bit patterns almost never produce. These include operands that are exactly equal, the two signed zeros, NaNs with a single fraction bit set, and infinities that must not be taken for NaNs. The stimulus therefore draws each operand from a weighted menu. The menu includes copying the other operand, flipping only its sign, and building special exponent patterns with a tiny or empty fraction. A directed set first covers negative-versus-negative ordering and the all-ones incoming flag word.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Relation between the two operands
    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Per-operand classification
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_zero;
    } opnd_class_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]   word_i,
    output opnd_class_t             cls_o,
    output logic [EXP_W+FRAC_W-1:0] mag_o
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f         = word_i[MAG_W-1:FRAC_W];
        frac_f        = word_i[FRAC_W-1:0];
        mag_o         = word_i[MAG_W-1:0];
        cls_o.sign    = word_i[MAG_W];
        cls_o.is_nan  = (&exp_f) && (|frac_f);
        cls_o.is_zero = ~|word_i[MAG_W-1:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  opnd_class_t      cls_a_i,
    input  opnd_class_t      cls_b_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic [MAG_W-1:0] mag_b_i,
    output rel_e             rel_o
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = mag_a_i < mag_b_i;
        mag_eq = mag_a_i == mag_b_i;
        if (cls_a_i.is_nan || cls_b_i.is_nan) begin
            rel_o = REL_UN;
        end else if (cls_a_i.is_zero && cls_b_i.is_zero) begin
            rel_o = REL_EQ;
        end else if (cls_a_i.sign != cls_b_i.sign) begin
            rel_o = cls_a_i.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (mag_lt ^ cls_a_i.sign) begin
            rel_o = REL_LT;
        end else begin
            rel_o = REL_GT;
        end
    end
endmodule

// File: rtl/fcmp_flag_merge.sv
module fcmp_flag_merge
    import fcmp_pkg::*;
#(
    parameter int FLAG_W = 16,
    parameter int CF_POS = 0,
    parameter int PF_POS = 2,
    parameter int AF_POS = 4,
    parameter int ZF_POS = 6,
    parameter int SF_POS = 7,
    parameter int OF_POS = 11
) (
    input  logic [FLAG_W-1:0] flags_i,
    input  rel_e              rel_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic zf_v;
    logic pf_v;
    logic cf_v;

    always_comb begin
        zf_v = (rel_i == REL_EQ) || (rel_i == REL_UN);
        pf_v = (rel_i == REL_UN);
        cf_v = (rel_i == REL_LT) || (rel_i == REL_UN);
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (i == ZF_POS) begin : g_zf
            assign flags_o[i] = zf_v;
        end else if (i == PF_POS) begin : g_pf
            assign flags_o[i] = pf_v;
        end else if (i == CF_POS) begin : g_cf
            assign flags_o[i] = cf_v;
        end else if (i == OF_POS || i == SF_POS || i == AF_POS) begin : g_clr
            assign flags_o[i] = 1'b0;
        end else begin : g_pass
            assign flags_o[i] = flags_i[i];
        end
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int FLAG_W = 16,
    parameter int CF_POS = 0,
    parameter int PF_POS = 2,
    parameter int AF_POS = 4,
    parameter int ZF_POS = 6,
    parameter int SF_POS = 7,
    parameter int OF_POS = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   opa_i,
    input  logic [EXP_W+FRAC_W:0]   opb_i,
    input  logic [FLAG_W-1:0]       flags_i,
    output logic                    out_valid,
    output logic [FLAG_W-1:0]       flags_o
);
    localparam int MAG_W = EXP_W + FRAC_W;

    typedef struct packed {
        logic              vld;
        logic [FLAG_W-1:0] flags;
    } state_t;

    opnd_class_t       cls_a;
    opnd_class_t       cls_b;
    logic [MAG_W-1:0]  mag_a;
    logic [MAG_W-1:0]  mag_b;
    rel_e              rel;
    logic [FLAG_W-1:0] flags_new;
    state_t            st_d;
    state_t            st_q;

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls_a (
        .word_i (opa_i),
        .cls_o  (cls_a),
        .mag_o  (mag_a)
    );

    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls_b (
        .word_i (opb_i),
        .cls_o  (cls_b),
        .mag_o  (mag_b)
    );

    fcmp_order #(.MAG_W(MAG_W)) i_order (
        .cls_a_i (cls_a),
        .cls_b_i (cls_b),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .rel_o   (rel)
    );

    fcmp_flag_merge #(
        .FLAG_W (FLAG_W),
        .CF_POS (CF_POS),
        .PF_POS (PF_POS),
        .AF_POS (AF_POS),
        .ZF_POS (ZF_POS),
        .SF_POS (SF_POS),
        .OF_POS (OF_POS)
    ) i_merge (
        .flags_i (flags_i),
        .rel_i   (rel),
        .flags_o (flags_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.flags = flags_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign flags_o   = st_q.flags;
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int FLAG_W = 16,
    parameter int CF_POS = 0,
    parameter int PF_POS = 2,
    parameter int AF_POS = 4,
    parameter int ZF_POS = 6,
    parameter int SF_POS = 7,
    parameter int OF_POS = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] opa_i,
    input logic [EXP_W+FRAC_W:0] opb_i,
    input logic [FLAG_W-1:0]     flags_i,
    input logic                  out_valid,
    input logic [FLAG_W-1:0]     flags_o
);
    localparam int MAG_W = EXP_W + FRAC_W;
    localparam logic [FLAG_W-1:0] OWNED =
        (FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << PF_POS) | (FLAG_W'(1) << AF_POS) |
        (FLAG_W'(1) << ZF_POS) | (FLAG_W'(1) << SF_POS) | (FLAG_W'(1) << OF_POS);

    logic nan_a;
    logic nan_b;
    assign nan_a = (&opa_i[MAG_W-1:FRAC_W]) && (|opa_i[FRAC_W-1:0]);
    assign nan_b = (&opb_i[MAG_W-1:FRAC_W]) && (|opb_i[FRAC_W-1:0]);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (nan_a || nan_b)) |=>
        (flags_o[ZF_POS] && flags_o[PF_POS] && flags_o[CF_POS]));

    // R5
    same_pattern_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opa_i == opb_i && !nan_a) |=>
        (flags_o[ZF_POS] && !flags_o[PF_POS] && !flags_o[CF_POS]));

    // R4
    legal_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!flags_o[PF_POS] || (flags_o[ZF_POS] && flags_o[CF_POS])));

    // R7
    cleared_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!flags_o[OF_POS] && !flags_o[SF_POS] && !flags_o[AF_POS]));

    // R8
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((flags_o & ~OWNED) == ($past(flags_i) & ~OWNED)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags_o));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .FLAG_W (FLAG_W),
    .CF_POS (CF_POS),
    .PF_POS (PF_POS),
    .AF_POS (AF_POS),
    .ZF_POS (ZF_POS),
    .SF_POS (SF_POS),
    .OF_POS (OF_POS)
) i_fcmp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .flags_i   (flags_i),
    .out_valid (out_valid),
    .flags_o   (flags_o)
);

// File: tb/test_fcmp_flag_unit.sv
`timescale 1ns/100ps
module test_fcmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [15:0] fin = '0;
    logic        out_valid;
    logic [15:0] fout;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] last_exp = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fcmp_flag_unit i_fcmp_flag_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opa_i     (opa),
        .opb_i     (opb),
        .flags_i   (fin),
        .out_valid (out_valid),
        .flags_o   (fout)
    );

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    // Expected flag word from the requirements (R3..R9)
    function automatic logic [15:0] exp_flags(input logic [63:0] a, b, input logic [15:0] f);
        logic [15:0] r;
        real ra, rb;
        r = f & ~16'h08D5;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (is_nan(a) || is_nan(b)) r = r | 16'h0045;
        else if (ra < rb)           r = r | 16'h0001;
        else if (ra == rb)          r = r | 16'h0040;
        return r;
    endfunction

    function automatic string rel_tag(input logic [63:0] a, b);
        if (is_nan(a) || is_nan(b)) return "R3";
        if ($bitstoreal(a) < $bitstoreal(b)) return "R4";
        if ($bitstoreal(a) == $bitstoreal(b)) return "R5";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge
    task automatic cmp(input logic [63:0] a, b, input logic [15:0] f, input string tag);
        logic [15:0] e;
        e = exp_flags(a, b, f);
        in_valid = 1'b1;
        opa = a;
        opb = b;
        fin = f;
        @(negedge clk);
        chk({tag, " R2 valid"}, 64'(out_valid), 64'd1);
        chk(tag, 64'(fout), 64'(e));
        last_exp = e;
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        opa = {$urandom, $urandom};
        opb = {$urandom, $urandom};
        fin = 16'($urandom);
        @(negedge clk);
        chk("R10 hold", 64'(fout), 64'(last_exp));
        chk("R2 idle", 64'(out_valid), 64'd0);
    endtask

    function automatic logic [63:0] pick(input logic [63:0] other);
        logic [63:0] v;
        case ($urandom % 9)
            0: v = other;
            1: v = other ^ 64'h8000_0000_0000_0000;
            2: v = {1'($urandom), 11'h7FF, 52'd1 << ($urandom % 52)};
            3: v = {1'($urandom), 11'h7FF, 52'd0};
            4: v = {1'($urandom), 63'd0};
            5: v = {1'($urandom), other[62:0] + 63'($urandom % 3) - 63'd1};
            6: v = {1'($urandom), 11'h3FF + 11'($urandom % 8), 52'($urandom)};
            default: v = {$urandom, $urandom};
        endcase
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'h1D5E_ED01));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset flags", 64'(fout), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({out_valid, fout}), 64'd0);

        cmp(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 16'h0000, "R4 1<2");
        cmp(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 16'h0000, "R6 2>1");
        cmp(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'h0000, "R5 +0==-0");
        cmp(64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 16'h0000, "R5 equal");
        cmp(64'hC008_0000_0000_0000, 64'hC000_0000_0000_0000, 16'h0000, "R9 -3<-2");
        cmp(64'hC000_0000_0000_0000, 64'hC008_0000_0000_0000, 16'h0000, "R9 -2>-3");
        cmp(64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 16'h0000, "R9 -1<1");
        cmp(64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 16'h0000, "R3 nan a");
        cmp(64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0001, 16'h0000, "R3 nan b");
        cmp(64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 16'h0000, "R9 +inf>-inf");
        cmp(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 16'h0000, "R9 inf==inf");
        cmp(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 16'hFFFF, "R7 R8 ones");
        cmp(64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 16'hA5A5, "R8 mixed");
        idle_cycle();
        idle_cycle();
        cmp(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 16'h5A5A, "R6 denorm");

        for (int i = 0; i < 400; i++) begin
            a = {$urandom, $urandom};
            if ($urandom % 3 == 0) a = pick(a);
            b = pick(a);
            cmp(a, b, 16'($urandom), rel_tag(a, b));
            if ($urandom % 4 == 0) idle_cycle();
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule